// File: doc/BRIEF.md
# Guard Timer with Register Bank

A 16-bit down-counting guard timer that software must service before it runs out. A prescaler slows the source clock by 1, 16, 256 or 4096. Every prescaler tick lowers the count by one. When a tick meets a count of zero, the timer has timed out. The timeout then does one of two things, depending on a control bit: it sends a one-cycle reset request to the reset generator, or it sets a pending interrupt flag for debug use.

Software works the timer through five registers on a simple single-cycle read/write bus: reload value, live count, control, clear and status. In periodic mode the counter reloads from the reload register after each timeout. In free-running mode it wraps to 0x1000. A hibernate input from the power manager can freeze the count and the prescaler. When hibernate ends, counting resumes from the frozen value without a reload.

Top module: `guard_timer`

## Requirements
- R1: After reset, offset 0x00 reads 0x1000, offset 0x04 reads 0x1000, offset 0x08 reads 0x00E9 and offset 0x18 reads 0x0000.
- R2: The register offsets are: reload 0x00 (read/write), count 0x04 (read-only), control 0x08 (read/write), clear 0x0C (write-only, reads 0) and status 0x18 (read-only). Writes to the count and status registers change nothing. Control bit 7 always reads 1, and bits 15:8 and bit 4 always read 0.
- R3: Control bits 3:2 select the prescale ratio: 00 is 1, 01 is 16, 10 is 256 and 11 is 4096. With the timer enabled, the count drops by one every ratio source cycles, counted from the last prescaler restart.
- R4: When control bit 6 is 1 (periodic), a tick at count zero is a timeout and loads the count from the reload register. A full period is therefore reload+1 ticks.
- R5: When control bit 6 is 0 (free running), a tick at count zero is a timeout and sets the count to 0x1000.
- R6: When control bit 1 is 0, a timeout raises rst_req_o for exactly one cycle, in the cycle after the timeout tick, and leaves irq_o low.
- R7: When control bit 1 is 1 and hibernate is low, a timeout sets irq_o and status bit 0. Both stay set until a clear is written, and rst_req_o stays low.
- R8: Any write to offset 0x0C loads the count from the reload register, drops irq_o and status bit 0, and sets status bit 1 for exactly the following cycle.
- R9: With control bit 0 set to 1, a high hib_i freezes both the count and the prescaler, and counting resumes from the frozen value once hib_i falls. With control bit 0 set to 0, counting carries on during hibernate.
- R10: A timeout while hib_i is high always raises rst_req_o, whatever the value of control bit 1.
- R11: While control bit 5 is 0, the count holds. The prescaler restarts from zero when bit 5 goes from 0 to 1, when bits 3:2 change, and when a clear is written.
- R12: A write to the reload register does not change the live count. The new value is used only at the next reload or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hib_i | input | 1 | Hibernate indication from the power manager |
| bus_sel_i | input | 1 | Bus select |
| bus_wr_i | input | 1 | Write strobe, qualified by bus_sel_i |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, decoded from bus_addr_i in the same cycle |
| rst_req_o | output | 1 | One-cycle reset request on timeout |
| irq_o | output | 1 | Pending debug interrupt |

## Verification
The countdown is driven with each of the four prescale codes, and the cycle of the first decrement after a clear is checked exactly. A wrong ratio or an off-by-one prescaler limit therefore shows up as a shifted edge. Periodic and free-running runs start from small reload values, so the value after zero (the reload value or 0x1000) tells the two modes apart. The timeout is routed with both settings of the interrupt select, inside and outside hibernate, which separates the reset path from the interrupt path and from the hibernate override. Hibernate is applied with both settings of the freeze bit. A disable/enable sequence is run with the prescaler stopped part-way through its period, which exposes a prescaler that fails to restart.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_LOAD = 5'h00;
  localparam logic [ADDR_W-1:0] A_CNT  = 5'h04;
  localparam logic [ADDR_W-1:0] A_CTL  = 5'h08;
  localparam logic [ADDR_W-1:0] A_CLR  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h18;

  typedef struct packed {
    logic       periodic;  // bit 6
    logic       en;        // bit 5
    logic [1:0] pre;       // bits 3:2
    logic       irq_sel;   // bit 1
    logic       freeze;    // bit 0
  } ctl_t;

  localparam ctl_t CTL_RST = '{periodic: 1'b1, en: 1'b1, pre: 2'b10,
                               irq_sel: 1'b0, freeze: 1'b1};
endpackage

// File: rtl/gt_prescaler.sv
module gt_prescaler #(
  parameter int unsigned STEP = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [1:0] pre_i,
  output logic       tick_o
);
  localparam int unsigned PSC_W = 3 * STEP;

  logic [PSC_W-1:0] lim [4];
  logic [PSC_W-1:0] psc_q, psc_d;
  logic             at_lim;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    localparam int unsigned LIM = (1 << (g * STEP)) - 1;
    assign lim[g] = PSC_W'(LIM);
  end

  assign at_lim = (psc_q == lim[pre_i]);
  assign tick_o = run_i && at_lim;

  always_comb begin
    psc_d = psc_q;
    if (restart_i)   psc_d = '0;
    else if (run_i)  psc_d = at_lim ? '0 : psc_q + PSC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else         psc_q <= psc_d;
  end

  // R3
  psc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_q <= lim[pre_i]);

  // R9
  psc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(psc_q));
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int unsigned  CNT_W    = 16,
  parameter logic [CNT_W-1:0] RST_VAL  = 16'h1000,
  parameter logic [CNT_W-1:0] WRAP_VAL = 16'h1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             to_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign to_o    = tick_i && !clr_i && at_zero;
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                 cnt_d = load_i;
    else if (tick_i && at_zero) cnt_d = periodic_i ? load_i : WRAP_VAL;
    else if (tick_i)           cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RST_VAL;
    else         cnt_q <= cnt_d;
  end

  // R11
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));

  // R5
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_o && !periodic_i) |=> (cnt_q == WRAP_VAL));

  // R4
  cnt_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_o && periodic_i) |=> (cnt_q == $past(load_i)));
endmodule

// File: rtl/gt_regs.sv
module gt_regs
  import gt_pkg::*;
#(
  parameter int unsigned      CNT_W    = 16,
  parameter logic [CNT_W-1:0] LOAD_RST = 16'h1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        stat_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [CNT_W-1:0]  load_o,
  output ctl_t              ctl_o,
  output logic              clr_o,
  output logic              psc_restart_o
);
  logic [CNT_W-1:0] load_q, load_d;
  ctl_t             ctl_q, ctl_d, ctl_w;
  logic             wr_load, wr_ctl;

  assign wr_load = sel_i && wr_i && (addr_i == A_LOAD);
  assign wr_ctl  = sel_i && wr_i && (addr_i == A_CTL);
  assign clr_o   = sel_i && wr_i && (addr_i == A_CLR);

  assign ctl_w = '{periodic: wdata_i[6], en: wdata_i[5], pre: wdata_i[3:2],
                   irq_sel: wdata_i[1], freeze: wdata_i[0]};

  always_comb begin
    load_d = wr_load ? wdata_i : load_q;
    ctl_d  = wr_ctl  ? ctl_w   : ctl_q;
  end

  assign psc_restart_o = clr_o ||
    (wr_ctl && ((ctl_w.pre != ctl_q.pre) || (ctl_w.en && !ctl_q.en)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= LOAD_RST;
      ctl_q  <= CTL_RST;
    end else begin
      load_q <= load_d;
      ctl_q  <= ctl_d;
    end
  end

  assign load_o = load_q;
  assign ctl_o  = ctl_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_LOAD:  rdata_o = load_q;
      A_CNT:   rdata_o = cnt_i;
      A_CTL:   rdata_o = {{(CNT_W-8){1'b0}}, 1'b1, ctl_q.periodic, ctl_q.en,
                          1'b0, ctl_q.pre, ctl_q.irq_sel, ctl_q.freeze};
      A_STAT:  rdata_o = {{(CNT_W-2){1'b0}}, stat_i};
      default: rdata_o = '0;
    endcase
  end

  // R2
  ctl_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctl |=> $stable(ctl_q));

  // R12
  load_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_load |=> $stable(load_q));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gt_pkg::*;
#(
  parameter int unsigned      CNT_W    = 16,
  parameter int unsigned      STEP     = 4,
  parameter logic [CNT_W-1:0] LOAD_RST = 16'h1000,
  parameter logic [CNT_W-1:0] WRAP_VAL = 16'h1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hib_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  ctl_t             ctl;
  logic [CNT_W-1:0] load, cnt;
  logic             clr, psc_restart, run, tick, to;
  logic             irq_q, irq_d, rreq_q, rreq_d, busy_q, busy_d;
  logic             use_irq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  gt_regs #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) regs_i (
    .clk_i, .rst_ni(rst_n), .sel_i(bus_sel_i), .wr_i(bus_wr_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .cnt_i(cnt),
    .stat_i({busy_q, irq_q}), .rdata_o(bus_rdata_o), .load_o(load),
    .ctl_o(ctl), .clr_o(clr), .psc_restart_o(psc_restart)
  );

  assign run = ctl.en && !(hib_i && ctl.freeze);

  gt_prescaler #(.STEP(STEP)) psc_i (
    .clk_i, .rst_ni(rst_n), .run_i(run), .restart_i(psc_restart),
    .pre_i(ctl.pre), .tick_o(tick)
  );

  gt_counter #(.CNT_W(CNT_W), .RST_VAL(LOAD_RST), .WRAP_VAL(WRAP_VAL)) cnt_i (
    .clk_i, .rst_ni(rst_n), .tick_i(tick), .clr_i(clr),
    .periodic_i(ctl.periodic), .load_i(load), .cnt_o(cnt), .to_o(to)
  );

  assign use_irq = ctl.irq_sel && !hib_i;

  always_comb begin
    irq_d  = irq_q;
    if (clr)                 irq_d = 1'b0;
    else if (to && use_irq)  irq_d = 1'b1;
    rreq_d = to && !use_irq;
    busy_d = clr;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      rreq_q <= rreq_d;
      busy_q <= busy_d;
    end
  end

  assign rst_req_o = rreq_q;
  assign irq_o     = irq_q;

  // R10
  hib_forces_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (to && hib_i) |=> rst_req_o);

  // R7
  irq_route_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (to && ctl.irq_sel && !hib_i) |=> (irq_o && !rst_req_o));

  // R8
  clear_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr |=> !irq_o);

  // R6
  rreq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rst_req_o && !$past(to)) |-> 1'b0);
endmodule

// File: tb/guard_timer_tb.sv
`timescale 1ns/100ps
module guard_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hib = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rreq, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [4:0] O_LOAD = 5'h00, O_CNT = 5'h04, O_CTL = 5'h08,
                         O_CLR = 5'h0C, O_STAT = 5'h18;

  always #2.5 clk = ~clk;

  guard_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hib_i(hib), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rst_req_o(rreq), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [15:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd_reg(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    chk_reg("R1 load", O_LOAD, 16'h1000);
    chk_reg("R1 count", O_CNT, 16'h1000);
    chk_reg("R1 control", O_CTL, 16'h00E9);
    chk_reg("R1 status", O_STAT, 16'h0000);
    chk("R1 outputs", {14'd0, rreq, irq}, 16'h0);
  endtask

  task automatic t_regmap;
    wr_reg(O_CTL, 16'h0041);
    wr_reg(O_LOAD, 16'h0033);
    wr_reg(O_CLR, 16'h0);
    wr_reg(O_CNT, 16'hBEEF);
    chk_reg("R2 count write ignored", O_CNT, 16'h0033);
    wr_reg(O_STAT, 16'hFFFF);
    chk_reg("R2 status write ignored", O_STAT, 16'h0000);
    wr_reg(O_CTL, 16'hFFFF);
    chk_reg("R2 control reserved bits", O_CTL, 16'h00EF);
    wr_reg(O_CTL, 16'h0041);
    chk_reg("R2 clear reads zero", O_CLR, 16'h0000);
    chk_reg("R2 load readback", O_LOAD, 16'h0033);
  endtask

  task automatic t_periodic;
    wr_reg(O_CTL, 16'h0061);
    wr_reg(O_LOAD, 16'd3);
    wr_reg(O_CLR, 16'h0);
    chk_reg("R4 count after clear", O_CNT, 16'd3);
    step(3);
    chk_reg("R4 count reaches zero", O_CNT, 16'd0);
    chk("R6 no request before tick", {15'd0, rreq}, 16'd0);
    step(1);
    chk_reg("R4 periodic reload", O_CNT, 16'd3);
    chk("R6 request pulse", {15'd0, rreq}, 16'd1);
    chk("R6 no interrupt", {15'd0, irq}, 16'd0);
    step(1);
    chk("R6 request one cycle", {15'd0, rreq}, 16'd0);
    chk_reg("R4 counting on", O_CNT, 16'd2);
  endtask

  task automatic t_freerun;
    wr_reg(O_CTL, 16'h0021);
    wr_reg(O_LOAD, 16'd2);
    wr_reg(O_CLR, 16'h0);
    step(3);
    chk_reg("R5 wrap value", O_CNT, 16'h1000);
    chk("R5 timeout on wrap", {15'd0, rreq}, 16'd1);
    step(1);
    chk_reg("R5 after wrap", O_CNT, 16'h0FFF);
  endtask

  task automatic t_irq;
    wr_reg(O_CTL, 16'h0063);
    wr_reg(O_LOAD, 16'd2);
    wr_reg(O_CLR, 16'h0);
    step(3);
    chk("R7 irq set", {15'd0, irq}, 16'd1);
    chk("R7 no reset request", {15'd0, rreq}, 16'd0);
    chk_reg("R7 status pending", O_STAT, 16'h0001);
    step(5);
    chk("R7 irq held", {15'd0, irq}, 16'd1);
    wr_reg(O_CLR, 16'h0);
    chk("R8 irq dropped", {15'd0, irq}, 16'd0);
    chk_reg("R8 status busy only", O_STAT, 16'h0002);
    chk_reg("R8 reload on clear", O_CNT, 16'd2);
    step(1);
    chk_reg("R8 busy one cycle", O_STAT, 16'h0000);
  endtask

  task automatic t_prescale(input logic [1:0] code, input int ratio);
    wr_reg(O_CTL, 16'h0061 | (16'(code) << 2));
    wr_reg(O_LOAD, 16'd100);
    wr_reg(O_CLR, 16'h0);
    step(ratio - 1);
    chk_reg($sformatf("R3 hold ratio %0d", ratio), O_CNT, 16'd100);
    step(1);
    chk_reg($sformatf("R3 first tick ratio %0d", ratio), O_CNT, 16'd99);
    step(ratio);
    chk_reg($sformatf("R3 second tick ratio %0d", ratio), O_CNT, 16'd98);
  endtask

  task automatic t_hib_freeze;
    wr_reg(O_CTL, 16'h0061);
    wr_reg(O_LOAD, 16'd50);
    wr_reg(O_CLR, 16'h0);
    step(5);
    chk_reg("R9 before hibernate", O_CNT, 16'd45);
    hib = 1'b1;
    step(10);
    chk_reg("R9 frozen", O_CNT, 16'd45);
    hib = 1'b0;
    step(3);
    chk_reg("R9 resumed", O_CNT, 16'd42);
  endtask

  task automatic t_hib_run;
    wr_reg(O_CTL, 16'h0060);
    wr_reg(O_LOAD, 16'd50);
    wr_reg(O_CLR, 16'h0);
    hib = 1'b1;
    step(5);
    chk_reg("R9 counts in hibernate", O_CNT, 16'd45);
    hib = 1'b0;
  endtask

  task automatic t_hib_reset;
    wr_reg(O_CTL, 16'h0062);
    wr_reg(O_LOAD, 16'd2);
    hib = 1'b1;
    wr_reg(O_CLR, 16'h0);
    step(3);
    chk("R10 reset in hibernate", {15'd0, rreq}, 16'd1);
    chk("R10 no irq in hibernate", {15'd0, irq}, 16'd0);
    hib = 1'b0;
  endtask

  task automatic t_enable;
    wr_reg(O_CTL, 16'h0041);
    wr_reg(O_LOAD, 16'd10);
    wr_reg(O_CLR, 16'h0);
    step(5);
    chk_reg("R11 disabled holds", O_CNT, 16'd10);
    wr_reg(O_CTL, 16'h0065);
    wr_reg(O_CLR, 16'h0);
    step(8);
    wr_reg(O_CTL, 16'h0045);
    step(4);
    wr_reg(O_CTL, 16'h0065);
    step(15);
    chk_reg("R11 prescaler restarted", O_CNT, 16'd10);
    step(1);
    chk_reg("R11 tick after restart", O_CNT, 16'd9);
  endtask

  task automatic t_load_defer;
    wr_reg(O_CTL, 16'h0061);
    wr_reg(O_LOAD, 16'd10);
    wr_reg(O_CLR, 16'h0);
    step(2);
    wr_reg(O_LOAD, 16'd20);
    chk_reg("R12 count unaffected", O_CNT, 16'd7);
    chk_reg("R12 load stored", O_LOAD, 16'd20);
    wr_reg(O_CLR, 16'h0);
    chk_reg("R12 used at clear", O_CNT, 16'd20);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    t_periodic();
    t_freerun();
    t_irq();
    t_prescale(2'b00, 1);
    t_prescale(2'b01, 16);
    t_prescale(2'b10, 256);
    t_prescale(2'b11, 4096);
    t_hib_freeze();
    t_hib_run();
    t_hib_reset();
    t_enable();
    t_load_defer();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule